// File: doc/BRIEF.md
# Front-End Configuration Access Sequencer

This block sits on the host side of a front-end readout chip and carries out one configuration register access for each command. Software supplies the direction (read or write), a chip ID, an internal register address and, for writes, the data. The sequencer then acts as master on a small memory-mapped register bus. It loads the programming interface registers in a fixed order and fires the serial transfer. For reads it polls a readback status word until the busy bit drops. In every case it finishes by returning the interface to operating mode.

Each internal register is 8 or 10 bits wide. Address 11 is the only 10-bit register. The sequencer sets the width flag, masks write data to the active width and zero-extends read data. An address outside 1..13 is refused at once, with no bus traffic. A read that stays busy for too long is ended with an error, and the mode restore still runs.

Top module: `cfg_seq_top`

## Requirements
- R1: A valid write issues exactly four bus writes, in this order: data register (offset 0x00), control register (0x04), trigger register (0x08), mode register (0x10) with value 0x0000. There are no bus reads.
- R2: A valid read issues bus writes to the control, trigger and mode registers in that order, with no data register write. Between the trigger and the mode write it issues only bus reads of the readback register (0x0C).
- R3: The control word holds the internal address in bits [3:0], the chip ID in bits [11:8], and in bit 15 a 1 for a read or a 0 for a write. All other bits are 0.
- R4: The trigger write always carries 0x0A40: operation code 0x40 in bits [7:0] and transfer length 10 in bits [15:8].
- R5: Polling continues while readback bit 15 is 1. The first readback with bit 15 at 0 ends the poll, so N busy replies give N+1 bus reads.
- R6: Read data is readback bits [9:0] for address 11 and bits [7:0] zero-extended for every other address. Bits [14:10] are ignored.
- R7: The data word holds the write data in bits [9:0] and the width flag in bit 15 (1 = 10-bit). Address 11 sets the flag and passes 10 bits. Other addresses clear the flag and force bits [9:8] to 0.
- R8: A command to address 0, 14 or 15 gets a response with the error flag set and read data 0, and no bus transaction at all.
- R9: After POLL_LIMIT (default 1024) busy replies, the read ends with the error flag set and read data 0. The mode register write still follows, and there are no further polls.
- R10: cmd_ready is high only when the block is idle. Commands offered while busy are ignored. Every accepted command produces exactly one single-cycle rsp_valid pulse.
- R11: While bus_valid is high and bus_ready is low, bus_valid, bus_we, bus_addr and bus_wdata hold their values.
- R12: During and after reset, bus_valid and rsp_valid are 0. Once reset is released, cmd_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken on valid and ready |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_chip | input | 4 | Target chip ID |
| cmd_addr | input | 4 | Internal register address |
| cmd_wdata | input | 10 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Bad address or poll timeout |
| rsp_rdata | output | 10 | Read data, zero-extended |
| bus_valid | output | 1 | Bus transaction request |
| bus_ready | input | 1 | Bus transaction completes this cycle |
| bus_we | output | 1 | 1 for bus write, 0 for bus read |
| bus_addr | output | 8 | Bus register offset |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, sampled on bus_ready |

## Verification
The poll timeout is the hardest case to reach from the ports. It needs a read whose readback word stays busy for a full POLL_LIMIT polls, while the mode restore must still follow. The bench's bus model holds bit 15 high for a programmed number of polls, so a count of 3000 drives the sequencer into the timeout path. The bench then checks that exactly 1024 reads come before the mode write. A second hard case is the bus stalling in the middle of a transaction. For this, the bench toggles bus_ready on alternate cycles for selected vectors.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_CTRL,
    ST_TRIG,
    ST_POLL,
    ST_MODE,
    ST_RESP
  } seq_state_e;

  // Trigger: length 10 in the upper byte, opcode 0x40 in the lower byte
  localparam logic [15:0] TRIG_WORD     = 16'h0A40;
  localparam logic [15:0] MODE_RUN_WORD = 16'h0000;
  localparam int          BUSY_BIT      = 15;
  localparam int          WIDE_FLAG_BIT = 15;
  localparam int          RD_FLAG_BIT   = 15;
  localparam int          CHIP_LSB      = 8;
  localparam int          ADDR_FIRST    = 1;
  localparam int          ADDR_LAST     = 13;
  localparam int          WIDE_ADDR     = 11;

endpackage

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
  import cfg_seq_pkg::*;
#(
  parameter int CHIP_W = 4,
  parameter int IA_W   = 4,
  parameter int DATA_W = 10,
  parameter int BUS_DW = 16
) (
  input  logic              write,
  input  logic [CHIP_W-1:0] chip,
  input  logic [IA_W-1:0]   addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              addr_ok,
  output logic              wide,
  output logic [BUS_DW-1:0] data_word,
  output logic [BUS_DW-1:0] ctrl_word
);

  localparam int NARROW_W = 8;

  always_comb begin
    addr_ok = (int'(addr) >= ADDR_FIRST) && (int'(addr) <= ADDR_LAST);
    wide    = (int'(addr) == WIDE_ADDR);

    data_word = '0;
    data_word[WIDE_FLAG_BIT] = wide;
    if (wide) begin
      data_word[DATA_W-1:0] = wdata;
    end else begin
      data_word[NARROW_W-1:0] = wdata[NARROW_W-1:0];
    end

    ctrl_word = '0;
    ctrl_word[RD_FLAG_BIT]          = ~write;
    ctrl_word[CHIP_LSB +: CHIP_W]   = chip;
    ctrl_word[0 +: IA_W]            = addr;
  end

endmodule

// File: rtl/cfg_poll_timer.sv
module cfg_poll_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit,
  output logic expired
);

  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en  = clr | hit;
    cnt_d   = clr ? '0 : cnt_q + 1'b1;
    expired = hit && (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_seq_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int BUS_AW   = 8,
  parameter int BUS_DW   = 16,
  parameter logic [BUS_AW-1:0] OFS_DATA = 8'h00,
  parameter logic [BUS_AW-1:0] OFS_CTRL = 8'h04,
  parameter logic [BUS_AW-1:0] OFS_TRIG = 8'h08,
  parameter logic [BUS_AW-1:0] OFS_RDBK = 8'h0C,
  parameter logic [BUS_AW-1:0] OFS_MODE = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic              dec_ok,
  input  logic              dec_wide,
  input  logic [BUS_DW-1:0] dec_data_word,
  input  logic [BUS_DW-1:0] dec_ctrl_word,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [BUS_DW-1:0] bus_wdata,
  input  logic [BUS_DW-1:0] bus_rdata,
  output logic              tmr_clr,
  output logic              tmr_hit,
  input  logic              tmr_expired
);

  localparam int NARROW_W = 8;

  seq_state_e        state_q, state_d;
  logic              wr_q;
  logic              wide_q;
  logic [BUS_DW-1:0] data_q, ctrl_q;
  logic              err_q, err_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              accept, xfer_done, busy_seen;
  logic [DATA_W-1:0] rd_extract;

  always_comb begin
    accept     = (state_q == ST_IDLE) && cmd_valid;
    xfer_done  = bus_valid && bus_ready;
    busy_seen  = (state_q == ST_POLL) && xfer_done && bus_rdata[BUSY_BIT];
    tmr_hit    = busy_seen;
    tmr_clr    = (state_q == ST_TRIG);
    rd_extract = wide_q ? bus_rdata[DATA_W-1:0]
                        : {{(DATA_W-NARROW_W){1'b0}}, bus_rdata[NARROW_W-1:0]};
  end

  // Next-state process
  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    rd_d    = rd_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        err_d   = ~dec_ok;
        rd_d    = '0;
        state_d = !dec_ok ? ST_RESP : (cmd_write ? ST_DATA : ST_CTRL);
      end
      ST_DATA: if (xfer_done) state_d = ST_CTRL;
      ST_CTRL: if (xfer_done) state_d = ST_TRIG;
      ST_TRIG: if (xfer_done) state_d = wr_q ? ST_MODE : ST_POLL;
      ST_POLL: if (xfer_done) begin
        if (!bus_rdata[BUSY_BIT]) begin
          rd_d    = rd_extract;
          state_d = ST_MODE;
        end else if (tmr_expired) begin
          err_d   = 1'b1;
          state_d = ST_MODE;
        end
      end
      ST_MODE: if (xfer_done) state_d = ST_RESP;
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Bus request decode
  always_comb begin
    bus_valid = 1'b1;
    bus_we    = 1'b1;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (state_q)
      ST_DATA: begin bus_addr = OFS_DATA; bus_wdata = data_q;        end
      ST_CTRL: begin bus_addr = OFS_CTRL; bus_wdata = ctrl_q;        end
      ST_TRIG: begin bus_addr = OFS_TRIG; bus_wdata = TRIG_WORD;     end
      ST_POLL: begin bus_addr = OFS_RDBK; bus_we    = 1'b0;          end
      ST_MODE: begin bus_addr = OFS_MODE; bus_wdata = MODE_RUN_WORD; end
      default: begin bus_valid = 1'b0;    bus_we    = 1'b0;          end
    endcase
    cmd_ready = (state_q == ST_IDLE);
    rsp_valid = (state_q == ST_RESP);
    rsp_err   = err_q;
    rsp_rdata = rd_q;
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      rd_q    <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      wide_q <= 1'b0;
      data_q <= '0;
      ctrl_q <= '0;
    end else if (accept) begin
      wr_q   <= cmd_write;
      wide_q <= dec_wide;
      data_q <= dec_data_word;
      ctrl_q <= dec_ctrl_word;
    end
  end

endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top #(
  parameter int CHIP_W     = 4,
  parameter int IA_W       = 4,
  parameter int DATA_W     = 10,
  parameter int BUS_AW     = 8,
  parameter int BUS_DW     = 16,
  parameter int POLL_LIMIT = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [CHIP_W-1:0] cmd_chip,
  input  logic [IA_W-1:0]   cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [BUS_DW-1:0] bus_wdata,
  input  logic [BUS_DW-1:0] bus_rdata
);

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              dec_ok, dec_wide;
  logic [BUS_DW-1:0] dec_data_word, dec_ctrl_word;
  logic              tmr_clr, tmr_hit, tmr_expired;
  logic              fsm_cmd_ready;
  logic              fsm_cmd_valid;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n    = rst_sync_q[1];
  assign cmd_ready     = fsm_cmd_ready & rst_core_n;
  assign fsm_cmd_valid = cmd_valid & rst_core_n;

  cfg_cmd_decode #(
    .CHIP_W (CHIP_W),
    .IA_W   (IA_W),
    .DATA_W (DATA_W),
    .BUS_DW (BUS_DW)
  ) u_decode (
    .write     (cmd_write),
    .chip      (cmd_chip),
    .addr      (cmd_addr),
    .wdata     (cmd_wdata),
    .addr_ok   (dec_ok),
    .wide      (dec_wide),
    .data_word (dec_data_word),
    .ctrl_word (dec_ctrl_word)
  );

  cfg_poll_timer #(
    .LIMIT (POLL_LIMIT)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clr     (tmr_clr),
    .hit     (tmr_hit),
    .expired (tmr_expired)
  );

  cfg_seq_fsm #(
    .DATA_W (DATA_W),
    .BUS_AW (BUS_AW),
    .BUS_DW (BUS_DW)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .cmd_valid     (fsm_cmd_valid),
    .cmd_ready     (fsm_cmd_ready),
    .cmd_write     (cmd_write),
    .dec_ok        (dec_ok),
    .dec_wide      (dec_wide),
    .dec_data_word (dec_data_word),
    .dec_ctrl_word (dec_ctrl_word),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err),
    .rsp_rdata     (rsp_rdata),
    .bus_valid     (bus_valid),
    .bus_ready     (bus_ready),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .tmr_clr       (tmr_clr),
    .tmr_hit       (tmr_hit),
    .tmr_expired   (tmr_expired)
  );

endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk #(
  parameter int IA_W   = 4,
  parameter int DATA_W = 10,
  parameter int BUS_AW = 8,
  parameter int BUS_DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic [IA_W-1:0]   cmd_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_we,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [BUS_DW-1:0] bus_wdata
);

  logic last_bad, last_narrow_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_bad       <= 1'b0;
      last_narrow_rd <= 1'b0;
    end else if (cmd_valid && cmd_ready) begin
      last_bad       <= (cmd_addr == '0) || (int'(cmd_addr) > 13);
      last_narrow_rd <= !cmd_write && (int'(cmd_addr) != 11);
    end
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R11

  AST_TRIG_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_we && bus_addr == 8'h08 |-> bus_wdata == 16'h0A40); // R4

  AST_READS_ONLY_RDBK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_we |-> bus_addr == 8'h0C); // R2

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !bus_valid && !rsp_valid); // R10

  AST_BAD_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    last_bad && !cmd_ready |-> !bus_valid); // R8

  AST_BAD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    last_bad && rsp_valid |-> rsp_err && rsp_rdata == '0); // R8

  AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && last_narrow_rd |-> rsp_rdata[DATA_W-1:8] == '0); // R6

endmodule

bind cfg_seq_top cfg_seq_chk #(
  .IA_W   (IA_W),
  .DATA_W (DATA_W),
  .BUS_AW (BUS_AW),
  .BUS_DW (BUS_DW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_write (cmd_write),
  .cmd_addr  (cmd_addr),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/tb_cfg_seq_top.sv
module tb_cfg_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 1024;

  typedef struct packed {
    logic        wr;
    logic [3:0]  chip;
    logic [3:0]  addr;
    logic [9:0]  wdata;
    logic [15:0] busy;
    logic        stall;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd3, 4'd10, 10'h396, 16'd0,    1'b0},
    '{1'b0, 4'd3, 4'd10, 10'h000, 16'd2,    1'b0},
    '{1'b1, 4'd5, 4'd11, 10'h2AB, 16'd0,    1'b1},
    '{1'b0, 4'd5, 4'd11, 10'h000, 16'd5,    1'b1},
    '{1'b0, 4'd1, 4'd1,  10'h000, 16'd0,    1'b0},
    '{1'b1, 4'd9, 4'd13, 10'h0FF, 16'd0,    1'b0},
    '{1'b0, 4'd9, 4'd13, 10'h000, 16'd1,    1'b1},
    '{1'b1, 4'd2, 4'd0,  10'h055, 16'd0,    1'b0},
    '{1'b0, 4'd2, 4'd14, 10'h000, 16'd0,    1'b0},
    '{1'b1, 4'd2, 4'd15, 10'h011, 16'd0,    1'b0},
    '{1'b1, 4'd15,4'd1,  10'h3FF, 16'd0,    1'b0},
    '{1'b0, 4'd15,4'd1,  10'h000, 16'd3,    1'b0}
  };

  logic        clk, rst_n;
  logic        cmd_valid, cmd_ready, cmd_write;
  logic [3:0]  cmd_chip, cmd_addr;
  logic [9:0]  cmd_wdata;
  logic        rsp_valid, rsp_err;
  logic [9:0]  rsp_rdata;
  logic        bus_valid, bus_ready, bus_we;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;

  int tests, fails;
  int rsp_cnt;
  logic        last_err;
  logic [9:0]  last_rdata;

  // bus / chip model state
  logic [7:0]  log_addr [256];
  logic [15:0] log_data [256];
  int          log_cnt, rd_cnt;
  logic [9:0]  mem [16];
  logic [9:0]  exp_mem [16];
  logic [15:0] mdl_data, mdl_ctrl;
  logic [15:0] poll_left, busy_cfg;
  logic [3:0]  rb_addr;
  logic        stall_en;
  logic [9:0]  rb_low;

  cfg_seq_top dut (
    .clk (clk), .rst_n (rst_n),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_write (cmd_write),
    .cmd_chip (cmd_chip), .cmd_addr (cmd_addr), .cmd_wdata (cmd_wdata),
    .rsp_valid (rsp_valid), .rsp_err (rsp_err), .rsp_rdata (rsp_rdata),
    .bus_valid (bus_valid), .bus_ready (bus_ready), .bus_we (bus_we),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // readback word: junk in [14:10], and junk in [9:8] for 8-bit registers
  assign rb_low    = (rb_addr == 4'd11) ? mem[rb_addr] : {2'b11, mem[rb_addr][7:0]};
  assign bus_rdata = (poll_left != 16'd0) ? 16'hFFFF : {1'b0, 5'b10110, rb_low};

  always @(posedge clk) begin
    if (bus_valid && bus_ready) begin
      if (bus_we) begin
        log_addr[log_cnt[7:0]] <= bus_addr;
        log_data[log_cnt[7:0]] <= bus_wdata;
        log_cnt <= log_cnt + 1;
        if (bus_addr == 8'h00) mdl_data <= bus_wdata;
        if (bus_addr == 8'h04) mdl_ctrl <= bus_wdata;
        if (bus_addr == 8'h08) begin
          if (!mdl_ctrl[15]) mem[mdl_ctrl[3:0]] <= mdl_data[9:0];
          rb_addr   <= mdl_ctrl[3:0];
          poll_left <= busy_cfg;
        end
      end else begin
        rd_cnt <= rd_cnt + 1;
        if (poll_left != 16'd0) poll_left <= poll_left - 16'd1;
      end
    end
  end

  always @(negedge clk) begin
    bus_ready <= stall_en ? ~bus_ready : 1'b1;
    if (rsp_valid) begin
      rsp_cnt    <= rsp_cnt + 1;
      last_err   <= rsp_err;
      last_rdata <= rsp_rdata;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input vec_t v);
    int lb, rb, rs;
    logic        wide, bad, tmo;
    logic [9:0]  m;
    logic [15:0] dw, cw;
    logic [9:0]  exp_rd;
    wide = (v.addr == 4'd11);
    bad  = (v.addr == 4'd0) || (v.addr > 4'd13);
    tmo  = !v.wr && (int'(v.busy) >= LIMIT);
    m    = wide ? v.wdata : {2'b00, v.wdata[7:0]};
    dw   = {wide, 5'b0, m};
    cw   = {~v.wr, 3'b0, v.chip, 4'b0, v.addr};
    exp_rd = (bad || tmo || v.wr) ? 10'h000 : exp_mem[v.addr];
    busy_cfg = v.busy;
    stall_en = v.stall;
    lb = log_cnt; rb = rd_cnt; rs = rsp_cnt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = v.wr; cmd_chip = v.chip;
    cmd_addr = v.addr; cmd_wdata = v.wdata;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 5000 && rsp_cnt == rs; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    stall_en = 1'b0;
    if (v.wr && !bad) exp_mem[v.addr] = m;
    check(rsp_cnt - rs == 1, "R10 one response", rsp_cnt - rs, 1);
    check(last_err == (bad || tmo), bad ? "R8 error flag" : "R9 error flag", last_err, bad || tmo);
    if (bad) begin
      check(log_cnt == lb && rd_cnt == rb, "R8 no bus traffic", log_cnt - lb + rd_cnt - rb, 0);
      check(last_rdata == 10'h0, "R8 rdata zero", last_rdata, 0);
    end else if (v.wr) begin
      check(log_cnt - lb == 4 && rd_cnt == rb, "R1 write count", log_cnt - lb, 4);
      check({log_addr[lb[7:0]], log_data[lb[7:0]]} == {8'h00, dw}, "R7 data word",
            {log_addr[lb[7:0]], log_data[lb[7:0]]}, {8'h00, dw});
      check({log_addr[8'(lb+1)], log_data[8'(lb+1)]} == {8'h04, cw}, "R3 ctrl word",
            {log_addr[8'(lb+1)], log_data[8'(lb+1)]}, {8'h04, cw});
      check({log_addr[8'(lb+2)], log_data[8'(lb+2)]} == 24'h080A40, "R4 trigger",
            {log_addr[8'(lb+2)], log_data[8'(lb+2)]}, 24'h080A40);
      check({log_addr[8'(lb+3)], log_data[8'(lb+3)]} == 24'h100000, "R1 mode restore",
            {log_addr[8'(lb+3)], log_data[8'(lb+3)]}, 24'h100000);
    end else begin
      check(log_cnt - lb == 3, "R2 write count", log_cnt - lb, 3);
      check({log_addr[lb[7:0]], log_data[lb[7:0]]} == {8'h04, cw}, "R3 R2 ctrl first",
            {log_addr[lb[7:0]], log_data[lb[7:0]]}, {8'h04, cw});
      check({log_addr[8'(lb+1)], log_data[8'(lb+1)]} == 24'h080A40, "R4 trigger",
            {log_addr[8'(lb+1)], log_data[8'(lb+1)]}, 24'h080A40);
      check({log_addr[8'(lb+2)], log_data[8'(lb+2)]} == 24'h100000, "R2 R9 mode restore",
            {log_addr[8'(lb+2)], log_data[8'(lb+2)]}, 24'h100000);
      check(rd_cnt - rb == (tmo ? LIMIT : int'(v.busy) + 1), tmo ? "R9 poll count" : "R5 poll count",
            rd_cnt - rb, tmo ? LIMIT : int'(v.busy) + 1);
      check(last_rdata == exp_rd, "R6 read data", last_rdata, exp_rd);
    end
  endtask

  initial begin
    tests = 0; fails = 0; rsp_cnt = 0; log_cnt = 0; rd_cnt = 0;
    last_err = 1'b0; last_rdata = '0;
    poll_left = '0; busy_cfg = '0; rb_addr = '0; stall_en = 1'b0;
    mdl_data = '0; mdl_ctrl = '0; bus_ready = 1'b1;
    for (int i = 0; i < 16; i++) begin
      mem[i]     = 10'((i * 37 + 5) & 10'h0FF);
      exp_mem[i] = 10'((i * 37 + 5) & 10'h0FF);
    end
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_chip = '0; cmd_addr = '0; cmd_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!bus_valid && !rsp_valid, "R12 quiet in reset", {bus_valid, rsp_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cmd_ready == 1'b1, "R12 ready after reset", cmd_ready, 1);
    check(!bus_valid && !rsp_valid, "R12 quiet after reset", {bus_valid, rsp_valid}, 0);

    for (int k = 0; k < NV; k++) run_cmd(VECS[k]);

    // R9: readback stuck busy
    run_cmd('{1'b0, 4'd7, 4'd2, 10'h000, 16'd3000, 1'b0});

    // R10: command offered while busy is ignored
    begin
      int lb, rs;
      lb = log_cnt; rs = rsp_cnt; busy_cfg = 16'd20;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = 1'b0; cmd_chip = 4'd1; cmd_addr = 4'd4;
      @(negedge clk);
      cmd_write = 1'b1; cmd_addr = 4'd0;
      for (int i = 0; i < 5; i++) begin
        check(cmd_ready == 1'b0, "R10 not ready while busy", cmd_ready, 0);
        @(negedge clk);
      end
      cmd_valid = 1'b0;
      for (int i = 0; i < 500 && rsp_cnt == rs; i++) @(negedge clk);
      repeat (10) @(negedge clk);
      check(rsp_cnt - rs == 1, "R10 single response", rsp_cnt - rs, 1);
      check(log_cnt - lb == 3, "R10 busy command ignored", log_cnt - lb, 3);
      check(last_err == 1'b0 && last_rdata == exp_mem[4], "R10 R6 original read kept",
            {last_err, last_rdata}, {1'b0, exp_mem[4]});
    end

    // R12: reset in the middle of an operation
    busy_cfg = 16'd50;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 4'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!bus_valid && !rsp_valid, "R12 mid-op reset quiet", {bus_valid, rsp_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cmd_ready == 1'b1, "R12 ready after mid-op reset", cmd_ready, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule